// File: doc/BRIEF.md
# Digitally Trimmed Seconds Prescaler

This block turns a free-running 32,768 Hz crystal clock into a one-cycle seconds pulse, and corrects crystal frequency error with digital trim rather than trim capacitors. A six-bit trim word carries a five-bit magnitude N and a direction bit. The block keeps its own count of seconds and minutes, and repeats a correction schedule every 64 minutes. In the first 2N minutes of that schedule, second 0 is either lengthened or shortened. The change is made at the fast (divide-by-256) stage of the divider. A lengthened second gains half a fast-stage period. A shortened second loses one whole fast-stage period.

A separate test output gives a square wave at 512 Hz, taken from the raw crystal count, so that the crystal can be measured on a bench without the trim getting in the way. An oscillator-stop input freezes every counter.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With trim magnitude 0, every second lasts exactly 2^LO_W * 2^HI_W running clock cycles, and `sec_tick_o` is high for one cycle per second.
- R2: Trim word layout: bits 4..0 hold the magnitude N and bit 5 holds the direction. Only second 0 of minutes 0 to 2N-1 of each 64-minute schedule is altered, and only once per second. Every other second is nominal, and minutes 62 and 63 are never altered.
- R3: With direction bit 0 (slow), an altered second lasts the nominal length plus 2^(LO_W-1) cycles.
- R4: With direction bit 1 (fast), an altered second lasts the nominal length minus 2^LO_W cycles.
- R5: One whole 64-minute schedule lasts 64*SEC_PER_MIN nominal seconds, plus 2N*2^(LO_W-1) cycles when slow or minus 2N*2^LO_W cycles when fast.
- R6: The trim word is captured while reset is asserted and at the tick that ends minute 63. A change to `cal_i` at any other time has no effect until the next schedule begins.
- R7: A clock edge with `osc_stop_i` high advances nothing. The current second grows by exactly the number of stopped edges, no tick is issued while stopped, and a pending adjustment is still applied exactly once.
- R8: While the test enable is active, `ft_o` changes level every 2^(FT_W-1) running cycles, independent of the trim word and of the adjustments.
- R9: `ft_o` is 0 during reset and within two cycles after `ft_en_i` falls. The internal enable clears on reset.
- R10: After reset, `sec_tick_o` and `ft_o` are 0, and the first tick arrives after one full second counted from the first edge with reset low, with the trim applied if minute 0 is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock, nominally 32,768 Hz |
| rst_i | input | 1 | Synchronous active-high reset |
| osc_stop_i | input | 1 | High freezes all counters |
| ft_en_i | input | 1 | Enables the 512 Hz test output |
| cal_i | input | 6 | Trim word: [4:0] magnitude, [5] direction (1 = fast) |
| sec_tick_o | output | 1 | One-cycle pulse per second, registered |
| ft_o | output | 1 | Test square wave, registered |

## Verification
The two functions that can collide are an oscillator stop and a trim adjustment. A stop can land on the exact edge where the fast stage wraps inside an eligible second, so the adjustment is due in the same cycle in which counting is frozen. The bench provokes this by timing the stop from the previous tick so that it covers that wrap edge, once in a fast schedule and once in a slow schedule, and then once in an unaltered second for comparison. It judges the result by measuring the affected second: it must equal the trimmed length plus the stopped edges, which shows the adjustment was deferred rather than lost or doubled. Meanwhile the test-output spacing, counted in running edges only, must stay unchanged.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int TRIM_MAG_W = 5;
  localparam int TRIM_W     = TRIM_MAG_W + 1;

  typedef enum logic {
    TRIM_SLOW = 1'b0,
    TRIM_FAST = 1'b1
  } trim_dir_e;

  typedef struct packed {
    trim_dir_e               dir;
    logic [TRIM_MAG_W-1:0]   mag;
  } trim_word_t;
endpackage

// File: rtl/rtcp_fine_div.sv
// Fast divider stage. An adjustment reloads the counter at half range,
// so the carry to the slow stage is blanked once and comes half a period later.
module rtcp_fine_div #(
  parameter int LO_W = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic stretch_i,
  output logic wrap_o,
  output logic carry_o
);
  localparam logic [LO_W-1:0] HALF = LO_W'(2 ** (LO_W - 1));

  logic [LO_W-1:0] lo_q;

  assign wrap_o  = run_i && (lo_q == '1);
  assign carry_o = wrap_o && !stretch_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lo_q <= '0;
    end else if (run_i) begin
      if (wrap_o) lo_q <= stretch_i ? HALF : '0;
      else        lo_q <= lo_q + 1'b1;
    end
  end

  // R3
  stretch_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_o && stretch_i) |=> (lo_q == HALF));

  // R7
  frozen_fine_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> $stable(lo_q));
endmodule

// File: rtl/rtcp_coarse_div.sv
// Slow divider stage. A skip request makes one carry advance it by two,
// which drops one fast-stage period from the second.
module rtcp_coarse_div #(
  parameter int HI_W = 7
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic carry_i,
  input  logic skip_i,
  output logic roll_o
);
  logic [HI_W-1:0] hi_q;

  assign roll_o = carry_i && (hi_q == '1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hi_q <= '0;
    end else if (carry_i) begin
      hi_q <= hi_q + (skip_i ? HI_W'(2) : HI_W'(1));
    end
  end

  // R4
  skip_jump_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (carry_i && skip_i) |=> (hi_q == HI_W'($past(hi_q) + 2)));
endmodule

// File: rtl/rtcp_trim_sched.sv
// Seconds/minutes bookkeeping, trim word capture and adjustment window.
module rtcp_trim_sched
  import rtcp_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       lo_wrap_i,
  input  logic       sec_roll_i,
  input  trim_word_t cal_i,
  output logic       stretch_o,
  output logic       skip_o
);
  localparam int SEC_W    = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_W    = TRIM_MAG_W + 1;
  localparam int CYC_MIN  = 2 ** MIN_W;
  localparam int ELIG_MIN = CYC_MIN - 2;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  trim_word_t       cal_q;
  logic             done_q;
  logic             sec_last;
  logic             min_last;
  logic             cyc_wrap;
  logic [MIN_W-1:0] win;
  logic             eligible;

  assign sec_last  = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign min_last  = (min_q == '1);
  assign cyc_wrap  = sec_roll_i && sec_last && min_last;
  assign win       = {cal_q.mag, 1'b0};
  assign eligible  = (sec_q == '0) && (min_q < win) && !done_q;
  assign stretch_o = eligible && (cal_q.dir == TRIM_SLOW);
  assign skip_o    = eligible && (cal_q.dir == TRIM_FAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q  <= '0;
      min_q  <= '0;
      done_q <= 1'b0;
      cal_q  <= cal_i;
    end else if (sec_roll_i) begin
      done_q <= 1'b0;
      if (sec_last) begin
        sec_q <= '0;
        min_q <= min_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
      if (cyc_wrap) cal_q <= cal_i;
    end else if (lo_wrap_i && eligible) begin
      done_q <= 1'b1;
    end
  end

  // R2
  elig_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (stretch_o || skip_o) |-> (int'(min_q) < ELIG_MIN));

  // R2
  single_fix_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (lo_wrap_i && (stretch_o || skip_o) && !sec_roll_i) |=> !(stretch_o || skip_o));

  // R6
  cal_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cyc_wrap |=> $stable(cal_q));
endmodule

// File: rtl/rtcp_freq_test.sv
// Test output from an untrimmed free-running count.
module rtcp_freq_test #(
  parameter int FT_W = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic ft_en_i,
  output logic ft_o
);
  logic [FT_W-1:0] cnt_q;
  logic [FT_W-1:0] cnt_nxt;
  logic            en_q;

  assign cnt_nxt = run_i ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      ft_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      en_q  <= ft_en_i;
      ft_o  <= en_q & cnt_nxt[FT_W-1];
    end
  end

  // R9
  ft_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q |=> !ft_o);
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtcp_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int FT_W        = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              osc_stop_i,
  input  logic              ft_en_i,
  input  logic [TRIM_W-1:0] cal_i,
  output logic              sec_tick_o,
  output logic              ft_o
);
  logic run;
  logic lo_wrap;
  logic lo_carry;
  logic sec_roll;
  logic stretch;
  logic skip;

  assign run = !osc_stop_i;

  rtcp_fine_div #(.LO_W(LO_W)) u_fine (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (run),
    .stretch_i (stretch),
    .wrap_o    (lo_wrap),
    .carry_o   (lo_carry)
  );

  rtcp_coarse_div #(.HI_W(HI_W)) u_coarse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .carry_i (lo_carry),
    .skip_i  (skip),
    .roll_o  (sec_roll)
  );

  rtcp_trim_sched #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .lo_wrap_i  (lo_wrap),
    .sec_roll_i (sec_roll),
    .cal_i      (trim_word_t'(cal_i)),
    .stretch_o  (stretch),
    .skip_o     (skip)
  );

  rtcp_freq_test #(.FT_W(FT_W)) u_ftest (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (run),
    .ft_en_i (ft_en_i),
    .ft_o    (ft_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) sec_tick_o <= 1'b0;
    else       sec_tick_o <= sec_roll;
  end

  // R1
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sec_tick_o |=> !sec_tick_o);

  // R7
  stop_no_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    osc_stop_i |=> !sec_tick_o);
endmodule

// File: tb/rtc_trim_prescaler_tb_top.sv
module rtc_trim_prescaler_tb_top;
  localparam int LO_W    = 3;
  localparam int HI_W    = 2;
  localparam int SPM     = 4;
  localparam int FT_W    = 3;
  localparam int L       = 1 << LO_W;
  localparam int P       = L * (1 << HI_W);
  localparam int CYC_SEC = 64 * SPM;
  localparam int NCYC    = 5;
  localparam int FT_HALF = 1 << (FT_W - 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_stop = 1'b0;
  logic       ft_en = 1'b1;
  logic [5:0] cal_in = 6'h00;
  logic       tick;
  logic       fto;

  always #10 clk = ~clk;

  rtc_trim_prescaler #(
    .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_MIN(SPM), .FT_W(FT_W)
  ) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .osc_stop_i (osc_stop),
    .ft_en_i    (ft_en),
    .cal_i      (cal_in),
    .sec_tick_o (tick),
    .ft_o       (fto)
  );

  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;
  int last_edge = 0;
  int tick_num = 0;
  int extra = 0;
  int cyc_acc = 0;
  int iv, ev, kk;
  int ft_run = 0;
  bit en_at_edge = 1'b1;
  bit ft_phase = 1'b0;
  bit ft_first = 1'b1;
  bit ft_last = 1'b0;
  bit done = 1'b0;
  string tag;
  logic [5:0] cal_seq [0:NCYC-1];

  task automatic check(input bit ok, input string t, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  function automatic bit is_fixed(int k);
    int c = k / CYC_SEC;
    int s = k % SPM;
    int m = (k / SPM) % 64;
    return (s == 0) && (m < 2 * int'(cal_seq[c][4:0]));
  endfunction

  function automatic int sec_len(int k);
    int c = k / CYC_SEC;
    if (!is_fixed(k)) return P;
    return cal_seq[c][5] ? P - L : P + L / 2;
  endfunction

  function automatic int cyc_len(int c);
    int n = int'(cal_seq[c][4:0]);
    return CYC_SEC * P + 2 * n * (cal_seq[c][5] ? -L : L / 2);
  endfunction

  always @(posedge clk) begin
    if (!rst) edge_cnt++;
    en_at_edge = !osc_stop;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (tick) begin
        kk = tick_num;
        iv = edge_cnt - last_edge;
        ev = sec_len(kk) + extra;
        if (extra > 0)                     tag = "R7";
        else if (kk == 0)                  tag = "R10";
        else if (kk % CYC_SEC == 0)        tag = "R6";
        else if (is_fixed(kk))             tag = cal_seq[kk / CYC_SEC][5] ? "R4" : "R3";
        else if (cal_seq[kk / CYC_SEC][4:0] == 5'd0) tag = "R1";
        else                               tag = "R2";
        check(iv == ev, tag, iv, ev);
        cyc_acc += iv - extra;
        extra = 0;
        last_edge = edge_cnt;
        if (kk % CYC_SEC == CYC_SEC - 1) begin
          ev = cyc_len(kk / CYC_SEC);
          check(cyc_acc == ev, "R5", cyc_acc, ev);
          cyc_acc = 0;
        end
        tick_num++;
      end
      if (ft_phase) begin
        if (en_at_edge) ft_run++;
        if (fto !== ft_last) begin
          if (!ft_first) check(ft_run == FT_HALF, "R8", ft_run, FT_HALF);
          ft_first = 1'b0;
          ft_run = 0;
          ft_last = fto;
        end
      end
    end
  end

  // Freeze the clock for k edges, starting on the first fast-stage wrap of the second.
  task automatic stall(input int k);
    extra = extra + k;
    repeat (L - 1) @(posedge clk);
    @(negedge clk);
    osc_stop = 1'b1;
    repeat (k) begin
      @(posedge clk);
      @(negedge clk);
      check(tick == 1'b0, "R7", int'(tick), 0);
    end
    osc_stop = 1'b0;
  endtask

  initial begin
    cal_seq[0] = 6'h3F;  // fast, 31
    cal_seq[1] = 6'h1F;  // slow, 31
    cal_seq[2] = 6'h21;  // fast, 1
    cal_seq[3] = 6'h05;  // slow, 5
    cal_seq[4] = 6'h20;  // fast, 0
    cal_in = cal_seq[0];
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R10", int'(tick), 0);
    check(fto == 1'b0, "R9", int'(fto), 0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    ft_phase = 1'b1;

    wait (tick_num == 4);              // fast-trimmed second 0 of minute 1
    stall(5);
    wait (tick_num == 100);
    cal_in = cal_seq[1];               // mid-schedule change, R6
    wait (tick_num == 200);
    ft_phase = 1'b0;
    ft_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(fto == 1'b0, "R9", int'(fto), 0);
    repeat (20) begin
      @(negedge clk);
      check(fto == 1'b0, "R9", int'(fto), 0);
    end

    wait (tick_num == CYC_SEC + 8);    // slow-trimmed second 0 of minute 2
    stall(7);
    wait (tick_num == CYC_SEC + 100);
    cal_in = cal_seq[2];
    wait (tick_num == 2 * CYC_SEC + 100);
    cal_in = cal_seq[3];
    wait (tick_num == 3 * CYC_SEC + 35); // untrimmed second
    stall(3);
    wait (tick_num == 3 * CYC_SEC + 100);
    cal_in = cal_seq[4];
    wait (tick_num == NCYC * CYC_SEC);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick_num, NCYC * CYC_SEC);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule